// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block is a small fully associative translation buffer for a processor memory unit. Each of its entries maps one aligned pair of virtual pages, an even page and an odd page, onto two independent physical frames. Page size is set per entry by a mask that widens the pair beyond the 8 KB minimum. Every entry carries an 8-bit address-space tag and a global flag. Each half of the pair has its own valid and writable ("dirty") flag.

A lookup presents a virtual address, the current address-space tag and a store flag. The tag is the low byte of the context register, which the surrounding core supplies. All active entries are compared in parallel. The lowest-index match decides the outcome. One clock later the block reports a physical address, read and write permissions, and a two-bit status that tells a clean hit apart from a miss, an invalid page and a store to a page that is not writable.

Entries are loaded through an index/data port. A live-entry count restricts the search to the lower entries.

Top module: `tlb_pair_lookup`

## Requirements
- R1: An entry takes part in a match only when its global flag is 1 or its stored address-space tag equals `lk_asid`. Otherwise it is skipped, and a lookup with no other candidate reports status NOMATCH (code 1).
- R2: The compare mask is the entry page mask placed at virtual bits 13 and up, ORed with ones in bits 12..0. The masked address must equal the masked stored pair number. An address one pair-size past the entry's base does not match.
- R3: The odd/even half is chosen by the virtual bit just above the half-mask, which is the top set bit of the compare mask. A 1 selects frame 1 with its valid and dirty flags, and a 0 selects frame 0 with its valid and dirty flags.
- R4: On a hit, `rs_pa` is the selected frame number shifted left by 12, ORed with the address bits under the half-mask. The status is HIT (code 0).
- R5: When the selected valid flag is 0, the status is INVALID (code 2) for reads and stores alike. In that case `rs_pa` is 0 and both permissions are 0.
- R6: On a hit, `rs_rd` is 1, and `rs_wr` equals the selected dirty flag. A store hit therefore always reports `rs_wr`=1.
- R7: A store (`lk_wr`=1) to a valid page whose dirty flag is 0 reports DIRTY (code 3), with `rs_pa` and both permissions 0. A read of the same page is a hit.
- R8: When several entries match, the lowest-index one alone decides the result, including an INVALID result that shadows a valid higher-index entry.
- R9: Loads write `wr_data` into entry `wr_idx` on the clock edge where `wr_en` is 1. A lookup registered on that same edge still sees the old entry, and the next lookup sees the new one. Results appear on the clock edge after the inputs are presented. The entry field order, from the most significant bit, is: pair number (19 bits, virtual bits 31..13), page mask (12), tag (8), global (1), frame 0 (20), valid 0, dirty 0, frame 1 (20), valid 1, dirty 1.
- R10: Only entries with index below `tlb_in_use` are searched. A count of 0 always yields NOMATCH.
- R11: A synchronous active-low reset sets status NOMATCH, `rs_pa` 0 and both permissions 0, and it clears every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load an entry this cycle |
| wr_idx | input | IDX_W | Index of the entry to load |
| wr_data | input | ENT_W (84) | Packed entry contents |
| tlb_in_use | input | CNT_W | Number of low entries that take part in the search |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag (low byte of the context register) |
| lk_wr | input | 1 | 1 for a store, 0 for a read |
| rs_pa | output | 32 | Translated physical address |
| rs_rd | output | 1 | Read permitted |
| rs_wr | output | 1 | Write permitted |
| rs_status | output | 2 | 0 HIT, 1 NOMATCH, 2 INVALID, 3 DIRTY |

## Verification
Sixteen entries are loaded with four page sizes and a spread of global, valid and dirty flags. Each entry is then probed at five offsets: low and high in the even half, low and high in the odd half, and just past the pair. Each probe is made as a read and as a store, under both the owning tag and a foreign tag. The offsets separate a wrong compare mask from a wrong half-select bit. The read/store pairs separate INVALID from DIRTY from HIT, and the foreign tag exposes a broken global override. A sweep of the live-entry count from 0 to 16 locates the search limit. Overlapping entries expose a wrong priority. A load followed at once by a lookup pins down the cycle in which a new entry becomes visible.

// File: rtl/tlbp_pkg.sv
// Shared widths, entry layout and status codes for the paired-page
// translation buffer. Assumes 4 KB minimum pages (pairs of 8 KB).
package tlbp_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int PG_SH   = 12;
    localparam int PAIR_SH = PG_SH + 1;
    localparam int PM_W    = 12;
    localparam int VPN2_W  = VA_W - PAIR_SH;
    localparam int PFN_W   = PA_W - PG_SH;
    localparam int TOP_PAD = VA_W - PAIR_SH - PM_W;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [PM_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic [PFN_W-1:0]  pfn0;
        logic              v0;
        logic              d0;
        logic [PFN_W-1:0]  pfn1;
        logic              v1;
        logic              d1;
    } tlb_ent_t;

    localparam int ENT_W = $bits(tlb_ent_t);

    typedef enum logic [1:0] {
        ST_HIT     = 2'd0,
        ST_NOMATCH = 2'd1,
        ST_INVALID = 2'd2,
        ST_DIRTY   = 2'd3
    } tlb_st_e;
endpackage

// File: rtl/tlbp_entry_store.sv
// Register file of translation entries with one index/data write port.
// Assumes wr_idx values at or above N are never presented with wr_en.
module tlbp_entry_store
    import tlbp_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_data,
    output tlb_ent_t         ents_o [N]
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        // Clear on reset, take new contents when this index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ents_o[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ents_o[g] <= wr_data;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (32'(wr_idx) < N) |=> ents_o[$past(wr_idx)] == $past(wr_data)); // R9
endmodule

// File: rtl/tlbp_match_cell.sv
// Compare logic for a single entry: tag/global check, masked pair compare,
// half select and physical address formation.
// Assumes the page mask is a run of ones starting at its bit 0.
module tlbp_match_cell
    import tlbp_pkg::*;
(
    input  tlb_ent_t          ent_i,
    input  logic [VA_W-1:0]   va_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic              active_i,
    output logic              hit_o,
    output logic              vld_o,
    output logic              drt_o,
    output logic [PA_W-1:0]   pa_o
);
    logic [VA_W-1:0]  cmp_m;
    logic [VA_W-1:0]  half_m;
    logic [VA_W-1:0]  sel_m;
    logic [VA_W-1:0]  tag_e;
    logic             odd;
    logic             own;
    logic [PFN_W-1:0] pfn;

    // Build compare mask, half mask and the single half-select bit.
    always_comb begin
        cmp_m  = {{TOP_PAD{1'b0}}, ent_i.pmask, {PAIR_SH{1'b1}}};
        half_m = cmp_m >> 1;
        sel_m  = cmp_m & ~half_m;
        tag_e  = {ent_i.vpn2, {PAIR_SH{1'b0}}};
    end

    // Decide match and pick the half's frame and flags.
    always_comb begin
        own   = ent_i.glb || (ent_i.asid == asid_i);
        hit_o = active_i && own && (((va_i ^ tag_e) & ~cmp_m) == '0);
        odd   = |(va_i & sel_m);
        pfn   = odd ? ent_i.pfn1 : ent_i.pfn0;
        vld_o = odd ? ent_i.v1 : ent_i.v0;
        drt_o = odd ? ent_i.d1 : ent_i.d0;
        pa_o  = {pfn, {PG_SH{1'b0}}} | PA_W'(va_i & half_m);
    end
endmodule

// File: rtl/tlbp_lowest_pick.sv
// Priority picker: returns the lowest set index of a hit vector.
// Assumes N is at least 2.
module tlbp_lowest_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     hits_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [N-1:0] ONE = N'(1);

    // Scan from the top so the lowest hit is written last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    AST_PICK_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> hits_i[idx_o]); // R8
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> ((hits_i & ((ONE << idx_o) - ONE)) == '0)); // R8
    AST_NONE_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> (hits_i == '0)); // R8
endmodule

// File: rtl/tlb_pair_lookup.sv
// Fully associative paired-page translation buffer, top level.
// Lookup inputs are sampled on a clock edge and the result is registered
// on that edge. Entries at index tlb_in_use and above are ignored.
module tlb_pair_lookup
    import tlbp_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int IDX_W = $clog2(N_ENT),
    parameter int CNT_W = $clog2(N_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  tlb_in_use,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_wr,
    output logic [PA_W-1:0]   rs_pa,
    output logic              rs_rd,
    output logic              rs_wr,
    output logic [1:0]        rs_status
);
    tlb_ent_t           ents [N_ENT];
    logic [N_ENT-1:0]   act;
    logic [N_ENT-1:0]   hits;
    logic [N_ENT-1:0]   c_vld;
    logic [N_ENT-1:0]   c_drt;
    logic [PA_W-1:0]    c_pa [N_ENT];
    logic               found;
    logic [IDX_W-1:0]   pick;
    tlb_st_e            st_d;
    logic [PA_W-1:0]    pa_d;
    logic               rd_d;
    logic               wr_d;

    tlbp_entry_store #(.N(N_ENT), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(tlb_ent_t'(wr_data)),
        .ents_o (ents)
    );

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cell
        assign act[gi] = (CNT_W'(gi) < tlb_in_use);
        tlbp_match_cell u_cell (
            .ent_i   (ents[gi]),
            .va_i    (lk_va),
            .asid_i  (lk_asid),
            .active_i(act[gi]),
            .hit_o   (hits[gi]),
            .vld_o   (c_vld[gi]),
            .drt_o   (c_drt[gi]),
            .pa_o    (c_pa[gi])
        );
    end

    tlbp_lowest_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .hits_i (hits),
        .found_o(found),
        .idx_o  (pick)
    );

    // Turn the winning entry's flags into status, address and permissions.
    always_comb begin
        st_d = ST_NOMATCH;
        pa_d = '0;
        rd_d = 1'b0;
        wr_d = 1'b0;
        if (found) begin
            if (!c_vld[pick]) begin
                st_d = ST_INVALID;
            end else if (lk_wr && !c_drt[pick]) begin
                st_d = ST_DIRTY;
            end else begin
                st_d = ST_HIT;
                pa_d = c_pa[pick];
                rd_d = 1'b1;
                wr_d = c_drt[pick];
            end
        end
    end

    // Register the lookup result; reset to an empty miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_status <= ST_NOMATCH;
            rs_pa     <= '0;
            rs_rd     <= 1'b0;
            rs_wr     <= 1'b0;
        end else begin
            rs_status <= st_d;
            rs_pa     <= pa_d;
            rs_rd     <= rd_d;
            rs_wr     <= wr_d;
        end
    end

    AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rs_wr |-> rs_rd); // R6
    AST_STORE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_status == 2'(ST_HIT)) && $past(lk_wr) && $past(rst_n) |-> rs_wr); // R6
    AST_DIRTY_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_status == 2'(ST_DIRTY)) |-> $past(lk_wr)); // R7
    AST_EMPTY_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(tlb_in_use) == '0) |-> (rs_status == 2'(ST_NOMATCH))); // R10
    AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_status != 2'(ST_HIT)) |-> (!rs_rd && (rs_pa == '0))); // R5
endmodule

// File: tb/tlb_pair_lookup_tb.sv
// Sweep bench for the paired-page translation buffer.
module tlb_pair_lookup_tb;
    import tlbp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int IDX_W = 4;
    localparam int CNT_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [ENT_W-1:0]  wr_data = '0;
    logic [CNT_W-1:0]  tlb_in_use = '0;
    logic [31:0]       lk_va = '0;
    logic [7:0]        lk_asid = '0;
    logic              lk_wr = 1'b0;
    logic [31:0]       rs_pa;
    logic              rs_rd;
    logic              rs_wr;
    logic [1:0]        rs_status;

    tlb_ent_t mdl [N];
    int       in_use_m = 0;
    int       total = 0;
    int       bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_pair_lookup #(.N_ENT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .tlb_in_use(tlb_in_use), .lk_va(lk_va), .lk_asid(lk_asid), .lk_wr(lk_wr),
        .rs_pa(rs_pa), .rs_rd(rs_rd), .rs_wr(rs_wr), .rs_status(rs_status)
    );

    // Expected result from pair sizes and offsets, first matching entry wins.
    function automatic void predict(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                                    output logic [1:0] st, output logic [31:0] pa,
                                    output logic rd, output logic wp);
        st = 2'd1; pa = '0; rd = 1'b0; wp = 1'b0;
        for (int i = 0; i < in_use_m; i++) begin
            longint pair = (longint'(mdl[i].pmask) + 1) * 8192;
            longint half = pair / 2;
            longint base = longint'(mdl[i].vpn2) * 8192;
            longint a    = longint'(va);
            logic   odd, v, d;
            longint pfn;
            if (!(mdl[i].glb || mdl[i].asid == asid)) continue;
            if ((a - a % pair) != (base - base % pair)) continue;
            odd = (a % pair) >= half;
            v   = odd ? mdl[i].v1 : mdl[i].v0;
            d   = odd ? mdl[i].d1 : mdl[i].d0;
            pfn = odd ? longint'(mdl[i].pfn1) : longint'(mdl[i].pfn0);
            if (!v) st = 2'd2;
            else if (wr && !d) st = 2'd3;
            else begin
                st = 2'd0; pa = 32'(pfn * 4096 + a % half); rd = 1'b1; wp = d;
            end
            return;
        end
    endfunction

    function automatic tlb_ent_t mk(input int i);
        tlb_ent_t e;
        int k = i % 4;
        e.vpn2  = VPN2_W'(i << 11);
        e.pmask = PM_W'((1 << (2 * k)) - 1);
        e.asid  = 8'((i * 37 + 5) & 255);
        e.glb   = (i % 3 == 0);
        e.pfn0  = PFN_W'((i + 1) << 8);
        e.pfn1  = PFN_W'((i + 65) << 8);
        e.v0    = (i % 5 != 4);
        e.d0    = i[0];
        e.v1    = (i % 7 != 6);
        e.d1    = !i[0] || (i % 3 == 1);
        return e;
    endfunction

    // Compare current outputs to the prediction for the current lookup inputs.
    task automatic sample_check(input string tag);
        logic [1:0] st; logic [31:0] pa; logic rd, wp;
        string t = tag;
        predict(lk_va, lk_asid, lk_wr, st, pa, rd, wp);
        if (st == 2'd2) t = "R5";
        if (st == 2'd3) t = "R7";
        total++;
        if (rs_status !== st || rs_pa !== pa || rs_rd !== rd || rs_wr !== wp) begin
            bad++;
            $display("FAIL %s va=%h asid=%h wr=%0d: got st=%0d pa=%h rd=%0d wr=%0d exp st=%0d pa=%h rd=%0d wr=%0d",
                     t, lk_va, lk_asid, lk_wr, rs_status, rs_pa, rs_rd, rs_wr, st, pa, rd, wp);
        end
    endtask

    task automatic lookup(input string tag, input logic [31:0] va, input logic [7:0] asid, input logic wr);
        lk_va = va; lk_asid = asid; lk_wr = wr;
        @(negedge clk);
        sample_check(tag);
    endtask

    task automatic load(input int i, input tlb_ent_t e);
        wr_en = 1'b1; wr_idx = IDX_W'(i); wr_data = e;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[i] = e;
    endtask

    task automatic set_count(input int c);
        tlb_in_use = CNT_W'(c); in_use_m = c;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got no end, exp finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tlb_ent_t e;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state while reset is held
        total++;
        if (rs_status !== 2'd1 || rs_pa !== 32'd0 || rs_rd !== 1'b0 || rs_wr !== 1'b0) begin
            bad++;
            $display("FAIL R11 reset: got st=%0d pa=%h rd=%0d wr=%0d exp st=1 pa=0 rd=0 wr=0",
                     rs_status, rs_pa, rs_rd, rs_wr);
        end
        rst_n = 1'b1;
        set_count(N);
        lookup("R11", 32'h0, 8'h55, 1'b0);
        lookup("R11", 32'h0, 8'h00, 1'b0);

        for (int i = 0; i < N; i++) load(i, mk(i));

        // Offsets x read/store x own/foreign tag for every entry.
        for (int i = 0; i < N; i++) begin
            logic [31:0] half = 32'(4096) << (2 * (i % 4));
            logic [31:0] base = 32'(i) << 24;
            logic [31:0] offs [5];
            offs[0] = 32'h10; offs[1] = half - 4; offs[2] = half + 32'h24;
            offs[3] = 2 * half - 4; offs[4] = 2 * half + 8;
            for (int o = 0; o < 5; o++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int f = 0; f < 2; f++) begin
                        string tg;
                        if (o == 4) tg = "R2";
                        else if (f == 1) tg = "R1";
                        else if (o >= 2) tg = "R3";
                        else if (w == 1) tg = "R6";
                        else tg = "R4";
                        lookup(tg, base + offs[o], mk(i).asid ^ 8'(f), 1'(w));
                    end
                end
            end
        end

        // R10: live-entry count sweep on entry 8.
        for (int c = 0; c <= N; c++) begin
            set_count(c);
            lookup("R10", (32'd8 << 24) + 32'h10, mk(8).asid, 1'b0);
        end
        set_count(N);

        // R9: write and lookup on the same edge see the old entry, next sees new.
        e = mk(5); e.pfn0 = 20'hABC00; e.v0 = 1'b1; e.d0 = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = e;
        lk_va = (32'd5 << 24) + 32'h10; lk_asid = mk(5).asid; lk_wr = 1'b1;
        @(negedge clk);
        sample_check("R9");
        wr_en = 1'b0; mdl[5] = e;
        @(negedge clk);
        sample_check("R9");

        // R8: overlapping global entries 2 and 10, lowest index decides.
        e = '0; e.vpn2 = VPN2_W'(32'h7000_0000 >> 13); e.glb = 1'b1;
        e.pfn0 = 20'h11100; e.v0 = 1'b1; e.d0 = 1'b1; e.pfn1 = 20'h11200; e.v1 = 1'b1; e.d1 = 1'b1;
        load(2, e);
        e.pfn0 = 20'h22200; e.pfn1 = 20'h22300;
        load(10, e);
        lookup("R8", 32'h7000_0123, 8'h99, 1'b1);
        lookup("R8", 32'h7000_1456, 8'h99, 1'b0);
        e = mdl[2]; e.v0 = 1'b0;
        load(2, e);
        lookup("R8", 32'h7000_0123, 8'h99, 1'b0);
        set_count(2);
        lookup("R10", 32'h7000_0123, 8'h99, 1'b0);
        set_count(11);
        lookup("R8", 32'h7000_1456, 8'h99, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule